// File: doc/BRIEF.md
# Memory Decoder Commit Controller

This block holds a bank of host address range decoders for a memory expander or switch port. Each decoder has a control word and three 64-bit range values: base, size and an auxiliary value. The auxiliary value is a list of downstream port identifiers in the switch build and a skip amount in the endpoint build. Each 64-bit value is reached as a low and a high 32-bit word. A read-only capability word reports how many decoders and targets exist and which groups of address bits may select the interleave.

Software loads a decoder's range words and then sets its commit bit. A fixed number of cycles later the decoder reports either committed or commit-error. The check rejects out-of-order commits and parameters the bank cannot support. A committed decoder raises its bit on `dec_active`, the claim signal for the address router. Clearing the commit bit returns the decoder to inactive. This is allowed only on the top decoder of the committed set, so the active decoders always form a contiguous run that starts at decoder 0. A locked and committed decoder accepts no writes until reset.

Top module: `memdec_commit_bank`

## Requirements
- R1: Reset clears every control word, range word and status bit, and drives `dec_active` to zero.
- R2: Word address 0 is the capability word. Bits [3:0] hold the decoder count, bits [11:4] the target count, bit 12 says address bits 11:8 may select the interleave, and bit 13 says the same for bits 14:12.
- R3: Decoder n occupies word addresses 8*(n+1) to 8*(n+1)+7. Offset 0 is control, offsets 1/2 are base low/high, 3/4 are size low/high, and 5/6 are the auxiliary value low/high. Reads of offset 7, of unused pages, and of the other words on page 0 return zero. Read data appears one cycle after `rd_addr`.
- R4: The control word holds granularity code [3:0], ways code [7:4], commit request [8], committed [9] (read-only), commit error [10] (read-only), lock [11] and target type [12] (1 = memory expander). Fields [12:11] and [7:0] take a write only while the commit request bit is clear.
- R5: After a write that sets the commit request, committed or commit error is set exactly COMMIT_LAT cycles later, never both, and `dec_active[n]` follows committed.
- R6: A commit of decoder n ends in commit error unless decoders 0 through n-1 are all committed at that moment.
- R7: A commit ends in commit error in any of these cases: the ways code is above 3 (codes 0..3 mean 1, 2, 4, 8 ways), 2^code exceeds the target count, the granularity code is above 6, or the size is not a multiple of the ways.
- R8: Writing the control word with the commit request clear clears the request, committed and error bits and drops `dec_active[n]`, while the other fields are kept. The write is ignored while decoder n+1 is committed or still awaiting its result.
- R9: While the commit request bit is set, writes to the base, size and auxiliary words are ignored.
- R10: A decoder that is committed with lock set ignores every write, including an uncommit, until reset.
- R11: In the switch build, auxiliary byte k (bits 8k+7:8k) holds target port k. Bytes at k >= target count always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_data | output | 32 | Read data, one cycle after rd_addr |
| dec_active | output | NUM_DEC | Per-decoder claim (committed) flags |

## Verification
A wrong commit countdown shows on `dec_active` and on the control word's status bits: the result arrives a cycle early or late relative to the write, and the bench samples the cycle before the deadline and the cycle of the deadline. A wrong ordering or neighbour flag shows as a decoder going active out of sequence, or an uncommit taking effect while a higher decoder is still claimed, within the same commit window. A frozen field that wrongly accepts a write shows on the next readback of that word, one cycle after its address is presented.

// File: rtl/memdec_pkg.sv
// Package memdec_pkg
// Shared control-word layout and register offsets for the decoder bank.
// Assumes a 32-bit register word and eight words per decoder page.
package memdec_pkg;

    // Control word, packed so that bit 0 is gran[0] and bit 12 is tgt_type.
    typedef struct packed {
        logic       tgt_type;   // 1 = memory expander
        logic       lock;
        logic       err;        // read-only commit error
        logic       done;       // read-only committed
        logic       req;        // commit request
        logic [3:0] ways;       // interleave ways code
        logic [3:0] gran;       // interleave granularity code
    } ctrl_t;

    localparam int CTRL_W   = 13;
    localparam int B_REQ    = 8;
    localparam int B_LOCK   = 11;
    localparam int B_TYPE   = 12;

    localparam logic [2:0] OFS_CTRL    = 3'd0;
    localparam logic [2:0] OFS_BASE_LO = 3'd1;
    localparam logic [2:0] OFS_BASE_HI = 3'd2;
    localparam logic [2:0] OFS_SIZE_LO = 3'd3;
    localparam logic [2:0] OFS_SIZE_HI = 3'd4;
    localparam logic [2:0] OFS_AUX_LO  = 3'd5;
    localparam logic [2:0] OFS_AUX_HI  = 3'd6;

    localparam int MAX_WAYS_CODE = 3;
    localparam int MAX_GRAN_CODE = 6;

endpackage

// File: rtl/memdec_validate.sv
// Module memdec_validate
// Pure combinational parameter check for one decoder's commit.
// Ways code c means 2^c ways; only codes up to MAX_WAYS_CODE exist.
// Assumes the caller samples ok only at the resolve cycle.
module memdec_validate
    import memdec_pkg::*;
#(
    parameter int NUM_TGT = 4
) (
    input  logic [3:0]  ways_code,
    input  logic [3:0]  gran_code,
    input  logic [63:0] size,
    output logic        ok
);

    logic        ways_ok;
    logic        gran_ok;
    logic        size_ok;
    logic [63:0] low_mask;

    // Evaluate the three parameter rules
    always_comb begin
        low_mask = (64'd1 << ways_code) - 64'd1;
        ways_ok  = (int'(ways_code) <= MAX_WAYS_CODE) &&
                   ((32'd1 << ways_code) <= 32'(NUM_TGT));
        gran_ok  = int'(gran_code) <= MAX_GRAN_CODE;
        size_ok  = (size & low_mask) == 64'd0;
        ok       = ways_ok && gran_ok && size_ok;
    end

endmodule

// File: rtl/memdec_slot.sv
// Module memdec_slot
// One decoder: control word, 64-bit base/size/aux, and the commit countdown.
// Assumes at most one write per cycle and that lower_done / upper_busy come
// from the neighbouring slots in the same cycle.
module memdec_slot
    import memdec_pkg::*;
#(
    parameter int NUM_TGT    = 4,
    parameter bit SWITCH     = 1'b1,
    parameter int COMMIT_LAT = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_ofs,
    input  logic [31:0] wr_data,
    input  logic        lower_done,
    input  logic        upper_busy,
    input  logic [2:0]  rd_ofs,
    output logic [31:0] rd_word,
    output logic        done,
    output logic        busy
);

    localparam int CNT_W = $clog2(COMMIT_LAT + 1);

    ctrl_t              ctrl_q;
    logic [63:0]        base_q;
    logic [63:0]        size_q;
    logic [63:0]        aux_q;
    logic               pend_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               params_ok;
    logic               frozen;
    logic               ctrl_wr;
    logic               start;
    logic               abort;
    logic               range_we;
    logic [63:0]        aux_mask;

    memdec_validate #(.NUM_TGT(NUM_TGT)) u_validate (
        .ways_code (ctrl_q.ways),
        .gran_code (ctrl_q.gran),
        .size      (size_q),
        .ok        (params_ok)
    );

    // Per-byte mask on the auxiliary value: switch builds drop absent targets
    generate
        if (SWITCH) begin : g_tgt_mask
            for (genvar b = 0; b < 8; b++) begin : g_byte
                assign aux_mask[8*b +: 8] = (b < NUM_TGT) ? 8'hFF : 8'h00;
            end
        end else begin : g_skip_mask
            assign aux_mask = '1;
        end
    endgenerate

    // Decode write intent for this slot
    always_comb begin
        frozen   = ctrl_q.done && ctrl_q.lock;
        ctrl_wr  = wr_en && (wr_ofs == OFS_CTRL) && !frozen;
        start    = ctrl_wr && !ctrl_q.req && wr_data[B_REQ];
        abort    = ctrl_wr && ctrl_q.req && !wr_data[B_REQ] && !upper_busy;
        range_we = wr_en && (wr_ofs != OFS_CTRL) && !ctrl_q.req && !frozen;
    end

    // Range words: writable only while no commit is requested
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            size_q <= '0;
            aux_q  <= '0;
        end else if (range_we) begin
            case (wr_ofs)
                OFS_BASE_LO: base_q[31:0]  <= wr_data;
                OFS_BASE_HI: base_q[63:32] <= wr_data;
                OFS_SIZE_LO: size_q[31:0]  <= wr_data;
                OFS_SIZE_HI: size_q[63:32] <= wr_data;
                OFS_AUX_LO:  aux_q[31:0]   <= wr_data & aux_mask[31:0];
                OFS_AUX_HI:  aux_q[63:32]  <= wr_data & aux_mask[63:32];
                default: ;
            endcase
        end
    end

    // Control word and commit countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            pend_q <= 1'b0;
            cnt_q  <= '0;
        end else if (abort) begin
            ctrl_q.req  <= 1'b0;
            ctrl_q.done <= 1'b0;
            ctrl_q.err  <= 1'b0;
            pend_q      <= 1'b0;
        end else begin
            if (ctrl_wr && !ctrl_q.req) begin
                ctrl_q.gran     <= wr_data[3:0];
                ctrl_q.ways     <= wr_data[7:4];
                ctrl_q.req      <= wr_data[B_REQ];
                ctrl_q.lock     <= wr_data[B_LOCK];
                ctrl_q.tgt_type <= wr_data[B_TYPE];
            end
            if (start) begin
                pend_q <= 1'b1;
                cnt_q  <= CNT_W'(COMMIT_LAT - 1);
            end else if (pend_q) begin
                if (cnt_q == '0) begin
                    pend_q <= 1'b0;
                    if (lower_done && params_ok) ctrl_q.done <= 1'b1;
                    else                          ctrl_q.err  <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    // Readback of this slot's words
    always_comb begin
        case (rd_ofs)
            OFS_CTRL:    rd_word = {{(32-CTRL_W){1'b0}}, ctrl_q};
            OFS_BASE_LO: rd_word = base_q[31:0];
            OFS_BASE_HI: rd_word = base_q[63:32];
            OFS_SIZE_LO: rd_word = size_q[31:0];
            OFS_SIZE_HI: rd_word = size_q[63:32];
            OFS_AUX_LO:  rd_word = aux_q[31:0];
            OFS_AUX_HI:  rd_word = aux_q[63:32];
            default:     rd_word = '0;
        endcase
    end

    assign done = ctrl_q.done;
    assign busy = ctrl_q.done || pend_q;

    // R5: committed and error are never both set
    p_status_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_q.done && ctrl_q.err));

    // R5: a countdown that reaches zero resolves on the next edge
    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && cnt_q == '0 && !abort) |=> (ctrl_q.done || ctrl_q.err));

    // R6: committed only rises when every lower decoder was committed
    p_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q.done) |-> $past(lower_done));

    // R9: range words hold while a commit is requested
    p_range_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.req |=> ($stable(base_q) && $stable(size_q) && $stable(aux_q)));

    // R10: a locked committed decoder does not change
    p_lock_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.done && ctrl_q.lock) |=> ($stable(ctrl_q) && $stable(base_q)));

endmodule

// File: rtl/memdec_readmux.sv
// Module memdec_readmux
// Selects the capability word or one slot's word by page and registers it.
// Assumes each slot already decodes the in-page offset.
module memdec_readmux #(
    parameter int NUM_DEC = 4,
    parameter int PAGE_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PAGE_W-1:0]       rd_page,
    input  logic [2:0]              rd_ofs,
    input  logic [31:0]             cap_word,
    input  logic [NUM_DEC-1:0][31:0] slot_words,
    output logic [31:0]             rd_data
);

    logic [31:0] sel;

    // Pick the word addressed by the page
    always_comb begin
        sel = '0;
        if (rd_page == '0 && rd_ofs == 3'd0) sel = cap_word;
        for (int k = 0; k < NUM_DEC; k++) begin
            if (int'(rd_page) == k + 1) sel = slot_words[k];
        end
    end

    // Register the read result
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= sel;
    end

endmodule

// File: rtl/memdec_commit_bank.sv
// Module memdec_commit_bank
// Bank of NUM_DEC address range decoders with an ordered commit protocol.
// Page 0 holds the capability word; decoder n lives on page n+1.
// Assumes a single register master issuing at most one write per cycle.
module memdec_commit_bank #(
    parameter int NUM_DEC    = 4,
    parameter int NUM_TGT    = 4,
    parameter int COMMIT_LAT = 4,
    parameter bit SWITCH     = 1'b1,
    parameter bit ILV_LO     = 1'b1,
    parameter bit ILV_HI     = 1'b0,
    localparam int ADDR_W    = $clog2(8 * (NUM_DEC + 1))
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [31:0]        wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [31:0]        rd_data,
    output logic [NUM_DEC-1:0] dec_active
);

    localparam int PAGE_W = ADDR_W - 3;

    logic [PAGE_W-1:0]        wr_page;
    logic [PAGE_W-1:0]        rd_page;
    logic [NUM_DEC-1:0]       done_v;
    logic [NUM_DEC-1:0]       busy_v;
    logic [NUM_DEC-1:0][31:0] slot_words;
    logic [31:0]              cap_word;

    assign wr_page  = wr_addr[ADDR_W-1:3];
    assign rd_page  = rd_addr[ADDR_W-1:3];
    assign cap_word = {18'd0, ILV_HI, ILV_LO, 8'(NUM_TGT), 4'(NUM_DEC)};

    // One slot per decoder, chained to its neighbours for ordering
    for (genvar i = 0; i < NUM_DEC; i++) begin : g_slot
        logic lower_done;
        logic upper_busy;
        if (i == 0) begin : g_first
            assign lower_done = 1'b1;
        end else begin : g_rest
            assign lower_done = &done_v[i-1:0];
        end
        if (i == NUM_DEC - 1) begin : g_last
            assign upper_busy = 1'b0;
        end else begin : g_mid
            assign upper_busy = busy_v[i+1];
        end
        memdec_slot #(
            .NUM_TGT    (NUM_TGT),
            .SWITCH     (SWITCH),
            .COMMIT_LAT (COMMIT_LAT)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (wr_en && (int'(wr_page) == i + 1)),
            .wr_ofs     (wr_addr[2:0]),
            .wr_data    (wr_data),
            .lower_done (lower_done),
            .upper_busy (upper_busy),
            .rd_ofs     (rd_addr[2:0]),
            .rd_word    (slot_words[i]),
            .done       (done_v[i]),
            .busy       (busy_v[i])
        );
    end

    memdec_readmux #(.NUM_DEC(NUM_DEC), .PAGE_W(PAGE_W)) u_readmux (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_page    (rd_page),
        .rd_ofs     (rd_addr[2:0]),
        .cap_word   (cap_word),
        .slot_words (slot_words),
        .rd_data    (rd_data)
    );

    assign dec_active = done_v;

    // R8: the active decoders always form a run starting at decoder 0
    p_prefix_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((done_v + 1'b1) & done_v) == '0);

endmodule

// File: tb/memdec_commit_bank_bench.sv
module memdec_commit_bank_bench;
    localparam int ND  = 4;
    localparam int NT  = 4;
    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [ND-1:0] dec_active;

    int total = 0;
    int bad   = 0;
    logic [31:0] q_exp[$];
    string       q_tag[$];

    always #5 clk = ~clk;

    memdec_commit_bank #(
        .NUM_DEC(ND), .NUM_TGT(NT), .COMMIT_LAT(LAT),
        .SWITCH(1'b1), .ILV_LO(1'b1), .ILV_HI(1'b0)
    ) u_memdec_commit_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .dec_active(dec_active)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] wa(int dec, int ofs);
        return 6'(8 * (dec + 1) + ofs);
    endfunction

    task automatic wr(int dec, int ofs, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = wa(dec, ofs); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // driver side of the scoreboard: queue the expected word, present address
    task automatic rd_exp(logic [5:0] a, logic [31:0] e, string tag);
        @(negedge clk);
        rd_addr = a;
        q_exp.push_back(e);
        q_tag.push_back(tag);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic act_chk(logic [ND-1:0] e, string tag);
        check(tag, 32'(dec_active), 32'(e));
    endtask

    // monitor side: compare the word registered after each queued address
    initial begin
        forever begin
            wait (q_exp.size() != 0);
            @(posedge clk);
            #1;
            check(q_tag.pop_front(), rd_data, q_exp.pop_front());
        end
    end

    initial begin
        #(200000 * 10);
        total++; bad++;
        $display("FAIL watchdog: actual=%h expected=%h", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        act_chk('0, "R1 active after reset");
        rd_exp(wa(0, 0), 32'h0, "R1 ctrl0 reset");
        rd_exp(wa(2, 3), 32'h0, "R1 size2 reset");
        // R2 capability
        rd_exp(6'd0, 32'h0000_1044, "R2 capability");
        // R3 map and unused words
        rd_exp(6'd1, 32'h0, "R3 page0 word1");
        wr(0, 2, 32'hDEAD_0001);
        wr(0, 1, 32'h4000_0000);
        wr(0, 3, 32'h1000_0000);
        rd_exp(wa(0, 2), 32'hDEAD_0001, "R3 base0 hi");
        rd_exp(wa(0, 1), 32'h4000_0000, "R3 base0 lo");
        rd_exp(wa(0, 7), 32'h0, "R3 reserved word");
        // R11 target bytes beyond target count
        wr(0, 5, 32'h0403_0201);
        wr(0, 6, 32'h0807_0605);
        rd_exp(wa(0, 5), 32'h0403_0201, "R11 targets lo");
        rd_exp(wa(0, 6), 32'h0, "R11 targets hi masked");
        // R6 out-of-order commit of decoder 1
        wr(1, 0, 32'h0000_0100);
        idle(LAT);
        rd_exp(wa(1, 0), 32'h0000_0500, "R6 out-of-order error");
        act_chk('0, "R6 nothing active");
        wr(1, 0, 32'h0);
        rd_exp(wa(1, 0), 32'h0, "R8 error cleared");
        // R5 commit decoder 0 with exact latency
        wr(0, 0, 32'h0000_1112);
        idle(LAT - 1);
        act_chk(4'b0000, "R5 not before deadline");
        idle(1);
        act_chk(4'b0001, "R5 committed at deadline");
        rd_exp(wa(0, 0), 32'h0000_1312, "R4 ctrl0 fields and status");
        // R9 range write while committed
        wr(0, 1, 32'h1234_5678);
        rd_exp(wa(0, 1), 32'h4000_0000, "R9 base0 frozen");
        // R7 ways beyond target count
        wr(1, 0, 32'h0000_0130);
        idle(LAT);
        rd_exp(wa(1, 0), 32'h0000_0530, "R7 eight ways rejected");
        wr(1, 0, 32'h0);
        rd_exp(wa(1, 0), 32'h0000_0030, "R8 fields kept on clear");
        // R7 size not a multiple of ways
        wr(1, 3, 32'h3);
        wr(1, 0, 32'h0000_0110);
        idle(LAT);
        rd_exp(wa(1, 0), 32'h0000_0510, "R7 size remainder rejected");
        wr(1, 0, 32'h0);
        wr(1, 3, 32'h4);
        wr(1, 0, 32'h0000_0110);
        idle(LAT);
        act_chk(4'b0011, "R6 in-order commit");
        // R8 uncommit of a lower decoder is ignored
        wr(0, 0, 32'h0);
        idle(1);
        act_chk(4'b0011, "R8 lower uncommit ignored");
        rd_exp(wa(0, 0), 32'h0000_1312, "R8 ctrl0 unchanged");
        // R8 uncommit of the top decoder
        wr(1, 0, 32'h0);
        act_chk(4'b0001, "R8 top uncommit");
        rd_exp(wa(1, 0), 32'h0000_0010, "R8 ctrl1 after uncommit");
        // R10 lock
        wr(1, 0, 32'h0000_0910);
        idle(LAT);
        act_chk(4'b0011, "R10 locked commit");
        wr(1, 0, 32'h0);
        wr(1, 3, 32'h8);
        act_chk(4'b0011, "R10 uncommit ignored");
        rd_exp(wa(1, 0), 32'h0000_0B10, "R10 ctrl1 locked");
        rd_exp(wa(1, 3), 32'h4, "R10 size1 frozen");
        // R7 granularity code out of range
        wr(2, 0, 32'h0000_0107);
        idle(LAT);
        rd_exp(wa(2, 0), 32'h0000_0507, "R7 granularity rejected");
        act_chk(4'b0011, "R7 active unchanged");
        // R1 reset clears lock and ranges
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        act_chk('0, "R1 active after second reset");
        rd_exp(wa(1, 0), 32'h0, "R1 ctrl1 after reset");
        rd_exp(wa(1, 3), 32'h0, "R1 size1 after reset");
        idle(3);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule